// File: doc/BRIEF.md
# Tag-Matched Event Router Buffer

This block is one crosspoint of a parallel event builder. It watches a shared input bus on which many unsynchronized detector sources place tagged data words. Each word names the event it belongs to and may close a fragment. The block keeps a small table of event tags assigned to its output. It stores only the words whose tag hits a live table entry. The words go into a dual-clock buffer and are replayed on an output farm bus at that bus's own rate, under a valid/ready handshake.

Words from different events may arrive interleaved and out of event order. When an entry has seen its expected number of fragment ends, the block appends a trailer word. The trailer carries the stored word count, a completion flag and a corruption flag. The entry is freed once that trailer has left on the output bus. If the buffer is too full, matching words are dropped, counted and flagged, and the input stream is never stalled. When the node-enable input is low, assignments are skipped entirely. An event may be loaded into more than one node, so that the copies can be compared downstream.

Top module: `evtRouteNode`

## Requirements
- R1: A word is stored only when `inValid` and `nodeEnable` are high and `inTag` equals the tag of a busy entry that is still collecting. If several entries match, the lowest-numbered one owns the word.
- R2: Words whose tag matches no collecting entry leave the buffer, the counters and the entries untouched.
- R3: Words of several events may be interleaved in any order. Stored words leave the output bus in their arrival order.
- R4: A write on `cfgWe` loads entry `cfgSlot` with `cfgTag` and a fragment target `cfgFrags` (at least 1), and makes it busy. The entry stops collecting on the word that brings its count of `inEof` words to the target. A dropped `inEof` word still counts toward the target.
- R5: On completion, a trailer is queued with `outTrailer`=1. Its fields are: bit 31 corrupt, bit 30 complete (1), bits 29:16 entry number, bits 15:0 stored word count. A data word always has write priority over a queued trailer. Among queued trailers, the lowest entry number is written first.
- R6: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outTrailer` stay unchanged.
- R7: A matching data word is stored only while the input-side occupancy plus the table size (4) is below 512, which keeps room for every trailer. A matching word that is not stored adds 1 to `overrunCount`, pulses `overrunPulse` one cycle later, and sets the corrupt bit of its event.
- R8: `slotBusy` for an entry drops after that entry's trailer has been accepted on the output bus.
- R9: While `nodeEnable` is low, matching words are neither stored nor counted as overruns, and the entry stays busy and collecting.
- R10: After reset, `slotBusy`, `overrunCount` and `outValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Input-bus clock |
| inRstN | input | 1 | Input-side reset, active low |
| inValid | input | 1 | A word is present on the input bus |
| inTag | input | 8 | Event tag of the input word |
| inData | input | 32 | Input word payload |
| inEof | input | 1 | Word closes a fragment |
| nodeEnable | input | 1 | Output processor available; low skips all assignments |
| cfgWe | input | 1 | Load an assignment entry |
| cfgSlot | input | 2 | Entry to load |
| cfgTag | input | 8 | Event tag for the entry |
| cfgFrags | input | 8 | Number of fragment ends expected |
| slotBusy | output | 4 | Entry is assigned and not yet drained |
| overrunCount | output | 16 | Number of dropped matching words |
| overrunPulse | output | 1 | One-cycle pulse per dropped word |
| outClk | input | 1 | Output farm bus clock |
| outRstN | input | 1 | Output-side reset, active low |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Output bus accepts the word |
| outData | output | 32 | Output word |
| outTrailer | output | 1 | Output word is an event trailer |

## Verification
The embedded properties watch the following on every cycle:
- No write reaches a full buffer.
- Only enabled input traffic produces stored data words or overrun pulses.
- The output word stays frozen while the farm bus stalls.

Tag filtering, interleaved ordering, trailer contents and priority, the exact overrun count, and entry release through the clock crossing are end-to-end effects. Only the directed scenarios show them, by comparing the full output stream and the status ports with values worked out from the requirements.

// File: rtl/evtRoutePkg.sv
package evtRoutePkg;
  localparam int DataW = 32;

  typedef struct packed {
    logic             we;
    logic             isTrailer;
    logic [DataW-1:0] word;
  } wrStrobeT;
endpackage

// File: rtl/evtRouteSync.sv
module evtRouteSync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/evtRouteBuf.sv
module evtRouteBuf
  import evtRoutePkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SLOTS  = 4
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  wrStrobeT          wrStb,
  output logic [ADDR_W:0]   wrCount,
  input  logic              rdClk,
  input  logic              rdRstN,
  output logic              outValid,
  input  logic              outReady,
  output logic [DataW-1:0]  outData,
  output logic              outTrailer,
  output logic [SLOTS-1:0]  relToggle
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SLOT_LSB = 16;

  function automatic logic [ADDR_W:0] toGray(input logic [ADDR_W:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [ADDR_W:0] fromGray(input logic [ADDR_W:0] g);
    logic [ADDR_W:0] b;
    b[ADDR_W] = g[ADDR_W];
    for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DataW:0] mem [DEPTH];

  // write side
  logic [ADDR_W:0] wrBin, wrGray, rdGraySyncW;
  logic            notFull, doWrite;

  evtRouteSync #(.W(ADDR_W + 1)) uRdPtrSync (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySyncW)
  );

  assign wrCount = wrBin - fromGray(rdGraySyncW);
  assign notFull = (wrCount != (ADDR_W + 1)'(DEPTH));
  assign doWrite = wrStb.we && notFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (doWrite) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (doWrite) mem[wrBin[ADDR_W-1:0]] <= {wrStb.isTrailer, wrStb.word};
  end

  // read side
  logic [ADDR_W:0] rdBin, rdGray, wrGraySyncR;
  logic [DataW:0]  headWord;
  logic            take;

  evtRouteSync #(.W(ADDR_W + 1)) uWrPtrSync (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySyncR)
  );

  assign outValid   = (fromGray(wrGraySyncR) != rdBin);
  assign headWord   = mem[rdBin[ADDR_W-1:0]];
  assign outData    = headWord[DataW-1:0];
  assign outTrailer = headWord[DataW];
  assign take       = outValid && outReady;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      relToggle <= '0;
    end else if (take) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
      if (outTrailer)
        relToggle[outData[SLOT_LSB +: SLOT_W]] <= ~relToggle[outData[SLOT_LSB +: SLOT_W]];
    end
  end

  // R7: the controller never requests a write into a full buffer
  assert_no_overflow_R7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrStb.we |-> (wrCount < (ADDR_W + 1)'(DEPTH)));

  // R6: a stalled output word holds still
  assert_hold_stable_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outTrailer)));
endmodule

// File: rtl/evtRouteCtrl.sv
module evtRouteCtrl
  import evtRoutePkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 9,
  parameter int SLOTS   = 4,
  parameter int FRAG_W  = 8,
  parameter int COUNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [TAG_W-1:0]          inTag,
  input  logic [DataW-1:0]          inData,
  input  logic                      inEof,
  input  logic                      nodeEnable,
  input  logic                      cfgWe,
  input  logic [$clog2(SLOTS)-1:0]  cfgSlot,
  input  logic [TAG_W-1:0]          cfgTag,
  input  logic [FRAG_W-1:0]         cfgFrags,
  input  logic [ADDR_W:0]           wrCount,
  input  logic [SLOTS-1:0]          relToggleAsync,
  output wrStrobeT                  wrStb,
  output logic [SLOTS-1:0]          slotBusy,
  output logic [COUNT_W-1:0]        overrunCount,
  output logic                      overrunPulse
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int SLOT_LSB = 16;

  logic [SLOTS-1:0]   busy, collecting, pend;
  logic [TAG_W-1:0]   slotTag    [SLOTS];
  logic [FRAG_W-1:0]  fragTarget [SLOTS];
  logic [FRAG_W-1:0]  fragSeen   [SLOTS];
  logic [COUNT_W-1:0] wordCnt    [SLOTS];
  logic [SLOTS-1:0]   corrupt;

  // release handshake from the output domain
  logic [SLOTS-1:0] relSync, relPrev, relEdge;
  evtRouteSync #(.W(SLOTS)) uRelSync (
    .clk(clk), .rstN(rstN), .d(relToggleAsync), .q(relSync)
  );
  assign relEdge = relSync ^ relPrev;

  // tag match
  logic [SLOTS-1:0]  hitVec;
  logic              anyHit, hit, room, acceptData, dropWord;
  logic [SLOT_W-1:0] hitIdx, pendIdx;
  logic              anyPend, writeTrailer;
  logic [DataW-1:0]  trailerWord;

  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      hitVec[i] = busy[i] && collecting[i] && (slotTag[i] == inTag);
  end

  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitIdx = SLOT_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    pendIdx = '0;
    anyPend = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pendIdx = SLOT_W'(i);
        anyPend = 1'b1;
      end
    end
  end

  assign hit          = inValid && nodeEnable && anyHit;
  assign room         = (wrCount < (ADDR_W + 1)'(DEPTH - SLOTS));
  assign acceptData   = hit && room;
  assign dropWord     = hit && !room;
  assign writeTrailer = !acceptData && anyPend && (wrCount < (ADDR_W + 1)'(DEPTH));

  always_comb begin
    trailerWord = '0;
    trailerWord[DataW-1] = corrupt[pendIdx];
    trailerWord[DataW-2] = 1'b1;
    trailerWord[SLOT_LSB +: SLOT_W] = pendIdx;
    trailerWord[COUNT_W-1:0] = wordCnt[pendIdx];
  end

  always_comb begin
    wrStb.we        = acceptData || writeTrailer;
    wrStb.isTrailer = !acceptData && writeTrailer;
    wrStb.word      = acceptData ? inData : trailerWord;
  end

  // entry table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= '0;
      collecting   <= '0;
      pend         <= '0;
      corrupt      <= '0;
      relPrev      <= '0;
      overrunCount <= '0;
      overrunPulse <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        slotTag[i]    <= '0;
        fragTarget[i] <= '0;
        fragSeen[i]   <= '0;
        wordCnt[i]    <= '0;
      end
    end else begin
      relPrev      <= relSync;
      overrunPulse <= dropWord;
      if (dropWord) overrunCount <= overrunCount + 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
        if (cfgWe && (cfgSlot == SLOT_W'(i))) begin
          busy[i]       <= 1'b1;
          collecting[i] <= 1'b1;
          pend[i]       <= 1'b0;
          corrupt[i]    <= 1'b0;
          slotTag[i]    <= cfgTag;
          fragTarget[i] <= cfgFrags;
          fragSeen[i]   <= '0;
          wordCnt[i]    <= '0;
        end else begin
          if (relEdge[i]) busy[i] <= 1'b0;
          if (hit && (hitIdx == SLOT_W'(i))) begin
            if (acceptData) wordCnt[i] <= wordCnt[i] + 1'b1;
            else            corrupt[i] <= 1'b1;
            if (inEof) begin
              fragSeen[i] <= fragSeen[i] + 1'b1;
              if (fragSeen[i] + 1'b1 == fragTarget[i]) begin
                collecting[i] <= 1'b0;
                pend[i]       <= 1'b1;
              end
            end
          end
          if (writeTrailer && (pendIdx == SLOT_W'(i))) pend[i] <= 1'b0;
        end
      end
    end
  end

  assign slotBusy = busy;

  // R1: stored data words come only from enabled input traffic
  assert_capture_enabled_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.we && !wrStb.isTrailer) |-> (inValid && nodeEnable));

  // R9: a disabled node never reports an overrun
  assert_disabled_no_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> $past(inValid && nodeEnable));

  // R5: a trailer is never written in a cycle with a live input word for a collecting entry and room
  assert_data_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.isTrailer |-> !(inValid && nodeEnable && (|hitVec) && room));
endmodule

// File: rtl/evtRouteNode.sv
module evtRouteNode
  import evtRoutePkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 9,
  parameter int SLOTS   = 4,
  parameter int FRAG_W  = 8,
  parameter int COUNT_W = 16
) (
  input  logic                      inClk,
  input  logic                      inRstN,
  input  logic                      inValid,
  input  logic [TAG_W-1:0]          inTag,
  input  logic [DataW-1:0]          inData,
  input  logic                      inEof,
  input  logic                      nodeEnable,
  input  logic                      cfgWe,
  input  logic [$clog2(SLOTS)-1:0]  cfgSlot,
  input  logic [TAG_W-1:0]          cfgTag,
  input  logic [FRAG_W-1:0]         cfgFrags,
  output logic [SLOTS-1:0]          slotBusy,
  output logic [COUNT_W-1:0]        overrunCount,
  output logic                      overrunPulse,
  input  logic                      outClk,
  input  logic                      outRstN,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [DataW-1:0]          outData,
  output logic                      outTrailer
);
  wrStrobeT         wrStb;
  logic [ADDR_W:0]  wrCount;
  logic [SLOTS-1:0] relToggle;

  evtRouteCtrl #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS), .FRAG_W(FRAG_W), .COUNT_W(COUNT_W)
  ) uCtrl (
    .clk(inClk), .rstN(inRstN),
    .inValid(inValid), .inTag(inTag), .inData(inData), .inEof(inEof),
    .nodeEnable(nodeEnable),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgTag(cfgTag), .cfgFrags(cfgFrags),
    .wrCount(wrCount), .relToggleAsync(relToggle),
    .wrStb(wrStb), .slotBusy(slotBusy),
    .overrunCount(overrunCount), .overrunPulse(overrunPulse)
  );

  evtRouteBuf #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) uBuf (
    .wrClk(inClk), .wrRstN(inRstN), .wrStb(wrStb), .wrCount(wrCount),
    .rdClk(outClk), .rdRstN(outRstN),
    .outValid(outValid), .outReady(outReady),
    .outData(outData), .outTrailer(outTrailer),
    .relToggle(relToggle)
  );
endmodule

// File: tb/sim_evtRouteNode.sv
`timescale 1ns/1ps
module sim_evtRouteNode;
  logic        inClk = 0, outClk = 0;
  logic        inRstN = 0, outRstN = 0;
  logic        inValid = 0, inEof = 0, nodeEnable = 1;
  logic [7:0]  inTag = 0;
  logic [31:0] inData = 0;
  logic        cfgWe = 0;
  logic [1:0]  cfgSlot = 0;
  logic [7:0]  cfgTag = 0, cfgFrags = 0;
  logic [3:0]  slotBusy;
  logic [15:0] overrunCount;
  logic        overrunPulse;
  logic        outValid, outReady = 0, outTrailer;
  logic [31:0] outData;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 inClk = ~inClk;
  always #6 outClk = ~outClk;

  evtRouteNode u0 (
    .inClk(inClk), .inRstN(inRstN), .inValid(inValid), .inTag(inTag),
    .inData(inData), .inEof(inEof), .nodeEnable(nodeEnable),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgTag(cfgTag), .cfgFrags(cfgFrags),
    .slotBusy(slotBusy), .overrunCount(overrunCount), .overrunPulse(overrunPulse),
    .outClk(outClk), .outRstN(outRstN), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outTrailer(outTrailer)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic assignSlot(logic [1:0] s, logic [7:0] t, logic [7:0] f);
    @(negedge inClk);
    cfgWe = 1; cfgSlot = s; cfgTag = t; cfgFrags = f;
    @(negedge inClk);
    cfgWe = 0;
  endtask

  task automatic sendWord(logic [7:0] t, logic [31:0] d, logic e);
    @(negedge inClk);
    inValid = 1; inTag = t; inData = d; inEof = e;
  endtask

  task automatic idle(int n);
    @(negedge inClk);
    inValid = 0; inEof = 0;
    repeat (n) @(negedge inClk);
  endtask

  task automatic readWord(output logic [32:0] w);
    int guard = 0;
    @(negedge outClk);
    while (!outValid && guard < 200) begin
      @(negedge outClk);
      guard++;
    end
    w = {outTrailer, outData};
    if (!outValid) w = 33'h1_DEAD_DEAD;
    outReady = 1;
    @(negedge outClk);
    outReady = 0;
  endtask

  task automatic testReset();
    check("R10", "slotBusy after reset", slotBusy, 0);
    check("R10", "overrunCount after reset", overrunCount, 0);
    check("R10", "outValid after reset", outValid, 0);
  endtask

  task automatic testBasic();
    logic [32:0] w;
    assignSlot(0, 8'h11, 2);
    sendWord(8'h11, 32'hA0A0_0001, 0);
    sendWord(8'h22, 32'hBAD0_0000, 1);   // R2: foreign tag
    sendWord(8'h11, 32'hA0A0_0002, 1);
    sendWord(8'h11, 32'hA0A0_0003, 1);
    idle(20);
    readWord(w); check("R1", "basic word 0", w, {1'b0, 32'hA0A0_0001});
    readWord(w); check("R2", "foreign word skipped", w, {1'b0, 32'hA0A0_0002});
    readWord(w); check("R1", "basic word 2", w, {1'b0, 32'hA0A0_0003});
    readWord(w); check("R4", "basic trailer", w, {1'b1, 32'h4000_0003});
    repeat (10) @(negedge inClk);
    check("R8", "slot0 released", slotBusy, 4'b0000);
    check("R2", "no overrun from foreign tag", overrunCount, 0);
  endtask

  task automatic testInterleave();
    logic [32:0] w;
    assignSlot(1, 8'h31, 1);
    assignSlot(2, 8'h32, 1);
    sendWord(8'h31, 32'h3100_000A, 0);
    sendWord(8'h32, 32'h3200_000B, 0);
    sendWord(8'h32, 32'h3200_000C, 1);
    sendWord(8'h31, 32'h3100_000D, 1);
    idle(20);
    readWord(w); check("R3", "interleave 0", w, {1'b0, 32'h3100_000A});
    readWord(w); check("R3", "interleave 1", w, {1'b0, 32'h3200_000B});
    readWord(w); check("R3", "interleave 2", w, {1'b0, 32'h3200_000C});
    readWord(w); check("R5", "data before queued trailer", w, {1'b0, 32'h3100_000D});
    readWord(w); check("R5", "lower entry trailer first", w, {1'b1, 32'h4001_0002});
    readWord(w); check("R5", "second trailer", w, {1'b1, 32'h4002_0002});
    repeat (10) @(negedge inClk);
    check("R8", "slots 1,2 released", slotBusy, 4'b0000);
  endtask

  task automatic testDisabled();
    logic [32:0] w;
    nodeEnable = 0;
    assignSlot(3, 8'h40, 1);
    sendWord(8'h40, 32'hD1D1_D1D1, 1);
    idle(20);
    repeat (5) @(negedge outClk);
    check("R9", "no output while disabled", outValid, 0);
    check("R9", "no overrun while disabled", overrunCount, 0);
    check("R9", "entry still busy", slotBusy, 4'b1000);
    nodeEnable = 1;
    sendWord(8'h40, 32'hD2D2_D2D2, 1);
    idle(20);
    readWord(w); check("R9", "word after enable", w, {1'b0, 32'hD2D2_D2D2});
    readWord(w); check("R4", "trailer after enable", w, {1'b1, 32'h4003_0001});
    repeat (10) @(negedge inClk);
    check("R8", "slot3 released", slotBusy, 4'b0000);
  endtask

  task automatic testOverrun();
    logic [32:0] w;
    logic [31:0] held;
    int bad = 0;
    outReady = 0;
    assignSlot(0, 8'h05, 1);
    for (int i = 0; i < 600; i++) sendWord(8'h05, 32'(i), (i == 599));
    idle(30);
    check("R7", "overrun count", overrunCount, 92);
    @(negedge outClk);
    held = outData;
    repeat (6) @(negedge outClk);
    check("R6", "stalled word stable", {outValid, outData}, {1'b1, held});
    for (int i = 0; i < 508; i++) begin
      readWord(w);
      if (w !== {1'b0, 32'(i)}) bad++;
    end
    check("R7", "stored words mismatches", bad, 0);
    readWord(w); check("R7", "corrupt trailer", w, {1'b1, 32'hC000_01FC});
    repeat (10) @(negedge inClk);
    check("R8", "slot0 released after overrun", slotBusy, 4'b0000);
    check("R6", "buffer drained", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge inClk);
    inRstN = 1; outRstN = 1;
    repeat (3) @(negedge inClk);
    testReset();
    testBasic();
    testInterleave();
    testDisabled();
    testOverrun();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (cyc < 200000 && !finished) begin
      @(posedge inClk);
      cyc++;
    end
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule